// File: doc/BRIEF.md
# Time-Slot Interchange Switch

This block is a non-blocking time-division switch for four serial lanes in and four serial lanes out. Each lane carries a repeating frame of 32 byte-wide channels, sent one bit per two clock cycles, most significant bit first. All serial timing comes from the clock and a single frame-sync strobe. The block captures every incoming channel into a double-buffered sample store. Each outgoing channel is then rebuilt from any chosen lane and channel of the previous complete frame. Which source feeds which output is set by a per-output routing table.

Every output channel also has its own mode bits. These let it send the switched sample, send a fixed byte written by the host, or go undriven. A third bit drives a side-band control pin for that channel. A small register port gives the host access to a selector register, to both halves of the routing table, and to the last complete frame of received samples. A global enable input blanks every lane driver at once.

Top module: `tsi_switch`

## Requirements
- R1: A frame is 512 cycles: 32 channels of 8 bits, 2 cycles per bit. Sampling `frame_sync` high on a clock edge makes the next cycle position 0. Without it, the position counts up by one and wraps from 511 to 0.
- R2: Bit i (0 = MSB) of channel c on `sin[s]` occupies frame positions 16c+2i and 16c+2i+1. It is sampled at the second of the two.
- R3: When an output channel's drive bit is 1 and its message bit is 0, output lane s channel k in frame F+1 carries, MSB first on the same bit cells, the byte received in frame F on the lane in routing bits [6:5] and the channel in routing bits [4:0].
- R4: When the message bit (bit 1 of the mode word) is 1, the channel sends the full 8-bit routing word instead of a switched sample.
- R5: When the drive bit (bit 0 of the mode word) is 0, `sout_oe[s]` is low and `sout[s]` is 0 for that channel's 16 cycles.
- R6: `ext_ctl[s]` equals bit 2 of the mode word of the channel currently on lane s.
- R7: While `out_en` is low, every `sout_oe` bit is low, whatever the mode words hold.
- R8: An access with `host_addr[5]`=1 reaches the selector register. Bits [1:0] pick the lane and bits [4:3] pick the store: 01 = received samples, 10 = routing words, 11 = mode words. The other bits read back as 0.
- R9: With store 01 selected, a read of channel c returns the byte received on the chosen lane and channel in the last complete frame. Writes to this store have no effect.
- R10: Routing words read back all 8 bits. Mode words read back in bits [2:0], with bits [7:3] as 0.
- R11: When `host_sel` is high and `host_ack` is low on an edge, `host_ack` is high for exactly the next cycle. The write takes effect and `host_rdata` is valid in that cycle.
- R12: After reset, the position is 0, all lane drivers are off, `ext_ctl` is 0, and the selector register, routing words, mode words and sample store are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Switch clock, two cycles per serial bit |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_sync | input | 1 | One-cycle strobe that restarts the frame at position 0 |
| out_en | input | 1 | Global lane-driver enable, active high |
| sin | input | 4 | Serial input lanes |
| sout | output | 4 | Serial output lanes (0 when undriven) |
| sout_oe | output | 4 | Per-lane driver enable for the current channel |
| ext_ctl | output | 4 | Per-lane side-band control bit of the current channel |
| host_sel | input | 1 | Host access request, held until acknowledged |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 6 | Bit 5 selects the selector register; bits [4:0] select a channel |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, valid while `host_ack` is high |
| host_ack | output | 1 | One-cycle access acknowledge |

## Verification
The routing table is filled with a fixed-seed random map that mixes switched, message and undriven channels on every lane. Some channels route to a different lane, some to a different channel, and some back to themselves. Random frame data then runs through several free-running frames. Each output slot is compared with the sample received on its source one frame earlier. This separates a wrong bit order or cell phase from a wrong buffer bank or a wrong source lookup. The last frame is sent with the global enable low, which separates the per-channel drive bit from the global gate. Host reads of the sample store after the stream stops show whether the completed bank, and not the bank being filled, is the one exposed.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
  localparam int NSTR = 4;
  localparam int NCH  = 32;
  localparam int BW   = 8;
  localparam int CPB  = 2;
  localparam int SW   = $clog2(NSTR);
  localparam int CW   = $clog2(NCH);
  localparam int BIW  = $clog2(BW);
  localparam int PW   = $clog2(CPB);
  localparam int FW   = CW + BIW + PW;
  localparam int FRAME_LEN = NCH * BW * CPB;
  localparam int AW   = CW + 1;

  typedef logic [FW-1:0] pos_t;

  typedef struct packed {
    logic ext;
    logic msg;
    logic drive;
  } mode_t;

  typedef enum logic [1:0] {
    MS_NONE = 2'b00,
    MS_DATA = 2'b01,
    MS_ROUTE = 2'b10,
    MS_MODE = 2'b11
  } msel_e;

  function automatic logic [CW-1:0] chan_of(pos_t p);
    return p[FW-1 -: CW];
  endfunction

  function automatic logic [BIW-1:0] bit_of(pos_t p);
    return p[PW +: BIW];
  endfunction

  function automatic logic sample_pt(pos_t p);
    return p[PW-1:0] == PW'(CPB - 1);
  endfunction

  function automatic logic byte_end(pos_t p);
    return sample_pt(p) && (bit_of(p) == BIW'(BW - 1));
  endfunction
endpackage

// File: rtl/tsi_frame_ctr.sv
module tsi_frame_ctr
  import tsi_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic frame_sync,
  output pos_t pos,
  output logic frame_wrap
);
  localparam pos_t LAST = pos_t'(FRAME_LEN - 1);

  assign frame_wrap = frame_sync | (pos == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         pos <= '0;
    else if (frame_sync || pos == LAST) pos <= '0;
    else                                pos <= pos + 1'b1;
  end
endmodule

// File: rtl/tsi_rx_lane.sv
module tsi_rx_lane
  import tsi_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sin,
  input  pos_t          pos,
  output logic          byte_vld,
  output logic [BW-1:0] byte_out
);
  logic [BW-2:0] shreg;

  assign byte_vld = byte_end(pos);
  assign byte_out = {shreg, sin};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             shreg <= '0;
    else if (sample_pt(pos)) shreg <= byte_out[BW-2:0];
  end
endmodule

// File: rtl/tsi_data_mem.sv
module tsi_data_mem
  import tsi_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      frame_wrap,
  input  logic [NSTR-1:0]           wr_en,
  input  logic [CW-1:0]             wr_ch,
  input  logic [NSTR-1:0][BW-1:0]   wr_data,
  input  logic [NSTR-1:0][SW-1:0]   tx_str,
  input  logic [NSTR-1:0][CW-1:0]   tx_ch,
  output logic [NSTR-1:0][BW-1:0]   tx_byte,
  input  logic [SW-1:0]             hst_str,
  input  logic [CW-1:0]             hst_ch,
  output logic [BW-1:0]             hst_byte,
  output logic                      rd_bank
);
  logic          wr_bank;
  logic [BW-1:0] mem [2][NSTR][NCH];

  assign rd_bank = ~wr_bank;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_bank <= 1'b0;
      for (int b = 0; b < 2; b++)
        for (int s = 0; s < NSTR; s++)
          for (int c = 0; c < NCH; c++)
            mem[b][s][c] <= '0;
    end else begin
      for (int s = 0; s < NSTR; s++)
        if (wr_en[s]) mem[wr_bank][s][wr_ch] <= wr_data[s];
      if (frame_wrap) wr_bank <= ~wr_bank;
    end
  end

  for (genvar s = 0; s < NSTR; s++) begin : g_rd
    assign tx_byte[s] = mem[rd_bank][tx_str[s]][tx_ch[s]];
  end
  assign hst_byte = mem[rd_bank][hst_str][hst_ch];
endmodule

// File: rtl/tsi_switch.sv
module tsi_switch
  import tsi_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            frame_sync,
  input  logic            out_en,
  input  logic [NSTR-1:0] sin,
  output logic [NSTR-1:0] sout,
  output logic [NSTR-1:0] sout_oe,
  output logic [NSTR-1:0] ext_ctl,
  input  logic            host_sel,
  input  logic            host_wr,
  input  logic [AW-1:0]   host_addr,
  input  logic [BW-1:0]   host_wdata,
  output logic [BW-1:0]   host_rdata,
  output logic            host_ack
);
  pos_t                    pos;
  logic                    frame_wrap;
  logic                    rd_bank;
  logic [NSTR-1:0]         rx_vld;
  logic [NSTR-1:0][BW-1:0] rx_byte;
  logic [NSTR-1:0][SW-1:0] tx_str;
  logic [NSTR-1:0][CW-1:0] tx_ch;
  logic [NSTR-1:0][BW-1:0] tx_byte;
  logic [BW-1:0]           hst_byte;

  msel_e         sel_mem;
  logic [SW-1:0] sel_str;
  logic [BW-1:0] route [NSTR][NCH];
  mode_t         mode  [NSTR][NCH];

  wire           acc_go  = host_sel & ~host_ack;
  wire           ctl_hit = host_addr[CW];
  wire [CW-1:0]  acc_ch  = host_addr[CW-1:0];
  wire [CW-1:0]  cur_ch  = chan_of(pos);

  tsi_frame_ctr u_ctr (
    .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync),
    .pos(pos), .frame_wrap(frame_wrap)
  );

  for (genvar s = 0; s < NSTR; s++) begin : g_lane
    tsi_rx_lane u_rx (
      .clk(clk), .rst_n(rst_n), .sin(sin[s]), .pos(pos),
      .byte_vld(rx_vld[s]), .byte_out(rx_byte[s])
    );

    logic [BW-1:0] rt;
    mode_t         md;
    logic [BW-1:0] pick;
    always_comb begin
      rt = route[s][cur_ch];
      md = mode[s][cur_ch];
      tx_str[s] = rt[CW +: SW];
      tx_ch[s]  = rt[CW-1:0];
      pick = md.msg ? rt : tx_byte[s];
      sout_oe[s] = out_en & md.drive;
      sout[s] = sout_oe[s] & pick[BIW'(BW - 1) - bit_of(pos)];
      ext_ctl[s] = md.ext;
    end
  end

  tsi_data_mem u_dmem (
    .clk(clk), .rst_n(rst_n), .frame_wrap(frame_wrap),
    .wr_en(rx_vld), .wr_ch(cur_ch), .wr_data(rx_byte),
    .tx_str(tx_str), .tx_ch(tx_ch), .tx_byte(tx_byte),
    .hst_str(sel_str), .hst_ch(acc_ch), .hst_byte(hst_byte),
    .rd_bank(rd_bank)
  );

  logic [BW-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (ctl_hit) begin
      rd_mux[4:3]    = sel_mem;
      rd_mux[SW-1:0] = sel_str;
    end else begin
      unique case (sel_mem)
        MS_DATA:  rd_mux = hst_byte;
        MS_ROUTE: rd_mux = route[sel_str][acc_ch];
        MS_MODE:  rd_mux = BW'(mode[sel_str][acc_ch]);
        default:  rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      host_ack   <= 1'b0;
      host_rdata <= '0;
      sel_mem    <= MS_NONE;
      sel_str    <= '0;
      for (int s = 0; s < NSTR; s++)
        for (int c = 0; c < NCH; c++) begin
          route[s][c] <= '0;
          mode[s][c]  <= '0;
        end
    end else begin
      host_ack <= acc_go;
      if (acc_go) begin
        host_rdata <= rd_mux;
        if (host_wr) begin
          if (ctl_hit) begin
            sel_mem <= msel_e'(host_wdata[4:3]);
            sel_str <= host_wdata[SW-1:0];
          end else if (sel_mem == MS_ROUTE) begin
            route[sel_str][acc_ch] <= host_wdata;
          end else if (sel_mem == MS_MODE) begin
            mode[sel_str][acc_ch] <= mode_t'(host_wdata[2:0]);
          end
        end
      end
    end
  end
endmodule

// File: rtl/tsi_switch_chk.sv
module tsi_switch_chk
  import tsi_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            frame_sync,
  input logic            out_en,
  input logic [NSTR-1:0] sout,
  input logic [NSTR-1:0] sout_oe,
  input logic            host_sel,
  input logic            host_ack,
  input pos_t            pos,
  input logic            frame_wrap,
  input logic            rd_bank
);
  localparam pos_t LAST = pos_t'(FRAME_LEN - 1);

  // R1
  ctr_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_sync |=> pos == '0);

  // R1
  ctr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_sync && pos != LAST) |=> pos == pos_t'($past(pos) + 1'b1));

  // R3
  bank_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_wrap |=> rd_bank != $past(rd_bank));

  // R7
  global_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_en |-> sout_oe == '0);

  // R5
  quiet_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sout & ~sout_oe) == '0);

  // R11
  ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_ack |=> !host_ack);

  // R11
  ack_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_sel && !host_ack) |=> host_ack);
endmodule

bind tsi_switch tsi_switch_chk u_chk (
  .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .out_en(out_en),
  .sout(sout), .sout_oe(sout_oe), .host_sel(host_sel), .host_ack(host_ack),
  .pos(pos), .frame_wrap(frame_wrap), .rd_bank(rd_bank)
);

// File: tb/tb_tsi_switch.sv
module tb_tsi_switch;
  localparam int NF = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_sync = 1'b0;
  logic       out_en = 1'b1;
  logic [3:0] sin = '0;
  logic [3:0] sout, sout_oe, ext_ctl;
  logic       host_sel = 1'b0, host_wr = 1'b0;
  logic [5:0] host_addr = '0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic       host_ack;

  always #4 clk = ~clk;

  tsi_switch dut (
    .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .out_en(out_en),
    .sin(sin), .sout(sout), .sout_oe(sout_oe), .ext_ctl(ext_ctl),
    .host_sel(host_sel), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .host_ack(host_ack)
  );

  typedef struct {
    int         s;
    int         md;
    bit         drv;
    bit         ext;
    logic [7:0] b;
  } exp_t;

  exp_t       q[$];
  int         n_vec = 0, n_bad = 0;
  bit         done = 0;
  int         cur_f = -1, cur_n = 0;
  logic [7:0] in_data [NF][4][32];
  logic [7:0] rt_m [4][32];
  int         md_m [4][32];
  bit         ext_m [4][32];

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic host_xfer(input bit w, input logic [5:0] a, input logic [7:0] d, output logic [7:0] r);
    @(negedge clk);
    host_sel = 1'b1; host_wr = w; host_addr = a; host_wdata = d;
    @(negedge clk);
    while (!host_ack) @(negedge clk);
    r = host_rdata;
    host_sel = 1'b0; host_wr = 1'b0;
  endtask

  function automatic logic [7:0] mode_word(int s, int k);
    logic [7:0] w;
    w = '0;
    w[2] = ext_m[s][k];
    w[1] = (md_m[s][k] == 1);
    w[0] = (md_m[s][k] != 0);
    return w;
  endfunction

  // driver: serial stimulus and expected slots
  task automatic drive_frames();
    @(negedge clk); frame_sync = 1'b1;
    for (int f = 0; f < NF; f++) begin
      for (int n = 0; n < 512; n++) begin
        @(negedge clk);
        frame_sync = 1'b0;
        cur_f = f; cur_n = n;
        out_en = (f != NF - 1);
        for (int s = 0; s < 4; s++) sin[s] = in_data[f][s][n / 16][7 - (n % 16) / 2];
        if (n == 0 && f >= 1) begin
          for (int k = 0; k < 32; k++)
            for (int s = 0; s < 4; s++) begin
              exp_t e;
              e.s = s; e.md = md_m[s][k]; e.ext = ext_m[s][k];
              e.drv = (md_m[s][k] != 0) && (f != NF - 1);
              e.b = (md_m[s][k] == 1) ? rt_m[s][k] :
                    in_data[f-1][rt_m[s][k][6:5]][rt_m[s][k][4:0]];
              q.push_back(e);
            end
        end
      end
    end
    @(negedge clk); sin = '0; out_en = 1'b1;
  endtask

  // monitor: rebuild each output slot and compare with the queue head
  task automatic monitor_slots();
    logic [7:0] cap [4];
    logic [7:0] cap_oe [4];
    logic       cap_ext [4];
    do begin @(negedge clk); #1; end while (!(cur_f == 1 && cur_n == 0));
    for (int f = 1; f < NF; f++)
      for (int n = 0; n < 512; n++) begin
        if (!(f == 1 && n == 0)) begin @(negedge clk); #1; end
        if (n % 2 == 0)
          for (int s = 0; s < 4; s++) begin
            cap[s][7 - (n % 16) / 2]    = sout[s];
            cap_oe[s][7 - (n % 16) / 2] = sout_oe[s];
            if (n % 16 == 0) cap_ext[s] = ext_ctl[s];
          end
        if (n % 16 == 15)
          for (int s = 0; s < 4; s++) begin
            exp_t e;
            string tag;
            e = q.pop_front();
            if (f == NF - 1) tag = "R7 global gate";
            else if (e.md == 0) tag = "R5 undriven slot";
            else if (e.md == 1) tag = "R4 message slot";
            else tag = "R3 switched slot (R1 R2 timing)";
            if (e.drv)
              check(e.s == s && cap[s] == e.b && cap_oe[s] == 8'hFF, tag,
                    {cap_oe[s], cap[s]}, {8'hFF, e.b});
            else
              check(e.s == s && cap[s] == 8'h00 && cap_oe[s] == 8'h00, tag,
                    {cap_oe[s], cap[s]}, 16'h0);
            check(cap_ext[s] == e.ext, "R6 side-band bit", cap_ext[s], e.ext);
          end
      end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] r;
    for (int f = 0; f < NF; f++)
      for (int s = 0; s < 4; s++)
        for (int c = 0; c < 32; c++) in_data[f][s][c] = 8'($urandom(f * 1000 + s * 100 + c + 7));
    for (int s = 0; s < 4; s++)
      for (int k = 0; k < 32; k++) begin
        md_m[s][k]  = (k < 3) ? k : int'($urandom % 4);
        ext_m[s][k] = 1'($urandom % 2);
        if (md_m[s][k] == 1) rt_m[s][k] = 8'($urandom);
        else rt_m[s][k] = {1'b0, 2'($urandom % 4), 5'($urandom % 32)};
        if (k == 3) rt_m[s][k] = {1'b0, 2'(s), 5'(k)};
        if (md_m[s][k] == 3) md_m[s][k] = 2;
      end

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    check(sout_oe == 4'h0, "R12 drivers off", sout_oe, 0);
    check(ext_ctl == 4'h0, "R12 side-band clear", ext_ctl, 0);
    host_xfer(0, 6'h20, 8'h00, r);
    check(r == 8'h00, "R12 selector clear", r, 0);
    host_xfer(1, 6'h20, 8'h19, r);
    host_xfer(0, 6'h04, 8'h00, r);
    check(r == 8'h00, "R12 mode word clear", r, 0);

    // R11 acknowledge timing
    @(negedge clk);
    host_sel = 1'b1; host_wr = 1'b0; host_addr = 6'h20;
    @(negedge clk);
    check(host_ack == 1'b1, "R11 ack after one cycle", host_ack, 1);
    check(host_rdata == 8'h19, "R11 read data with ack", host_rdata, 8'h19);
    host_sel = 1'b0;
    @(negedge clk);
    check(host_ack == 1'b0, "R11 ack one cycle only", host_ack, 0);

    // R8 selector register, unused bits read 0
    host_xfer(1, 6'h20, 8'hFF, r);
    host_xfer(0, 6'h20, 8'h00, r);
    check(r == 8'h1B, "R8 selector readback", r, 8'h1B);

    // R10 mode word unused bits, routing word full width
    host_xfer(0, 6'h09, 8'h00, r);
    host_xfer(1, 6'h09, 8'hFF, r);
    host_xfer(0, 6'h09, 8'h00, r);
    check(r == 8'h07, "R10 mode word bits 7:3 zero", r, 8'h07);
    host_xfer(1, 6'h20, 8'h12, r);
    host_xfer(1, 6'h0A, 8'hA5, r);
    host_xfer(0, 6'h0A, 8'h00, r);
    check(r == 8'hA5, "R10 routing word readback", r, 8'hA5);

    // program the full map
    for (int s = 0; s < 4; s++) begin
      host_xfer(1, 6'h20, 8'(8'h10 | s), r);
      for (int k = 0; k < 32; k++) host_xfer(1, 6'(k), rt_m[s][k], r);
      host_xfer(1, 6'h20, 8'(8'h18 | s), r);
      for (int k = 0; k < 32; k++) host_xfer(1, 6'(k), mode_word(s, k), r);
    end

    fork
      drive_frames();
      monitor_slots();
    join

    // R9 sample store read and write-ignore, last complete frame
    for (int s = 0; s < 4; s++) begin
      host_xfer(1, 6'h20, 8'(8'h08 | s), r);
      foreach (in_data[0][0][c]) if (c % 9 == 0 || c == 31) begin
        host_xfer(0, 6'(c), 8'h00, r);
        check(r == in_data[NF-1][s][c], "R9 sample readback", r, in_data[NF-1][s][c]);
      end
    end
    host_xfer(1, 6'h20, 8'h08, r);
    host_xfer(1, 6'h05, ~in_data[NF-1][0][5], r);
    host_xfer(0, 6'h05, 8'h00, r);
    check(r == in_data[NF-1][0][5], "R9 write ignored", r, in_data[NF-1][0][5]);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule